// File: doc/BRIEF.md
# Banked Program Counter with Interrupt Vectoring

This block holds the 12-bit fetch address of a small 8-bit controller whose program space is two 2 KB banks, with bit 11 as the bank bit. Each cycle it acts on one set of command strobes. It can step to the next address, load a jump or call target, restore an address popped from the return stack, or enter an interrupt. It drives the push port of an external return stack and tells the memory system whether the current fetch goes to internal or external program memory.

A bank flag is written by two select commands. That flag supplies bit 11 on jumps and calls. Interrupt entry injects a call to a fixed vector and sets an in-service state. While that state is set, jumps and calls stay in bank 0. Return-from-interrupt clears the state. An interrupt request that arrives in the same cycle as a control transfer is held pending. The transfer completes first, and the vectoring happens on the next free cycle.

Top module: `pc_bank_seq`

## Requirements
- R1: Reset sets the program counter to 000h and clears the bank flag, the in-service state and any pending interrupt.
- R2: An increment changes only bits 10:0. 7FFh steps to 000h, FFFh steps to 800h, and bit 11 never changes.
- R3: Outside interrupt service, a jump or call loads bit 11 from the bank flag and bits 10:0 from the operand. The bank-1 select sets the flag and the bank-0 select clears it. If both are strobed together, the bank-1 select wins.
- R4: A call pulses push_en in its own cycle with push_addr equal to the current 12-bit program counter.
- R5: With no control transfer in the cycle and the block not in service, an external request vectors to 003h and a timer request vectors to 007h. If both are present, the external request wins. Entry pushes the full 12-bit current address and sets in-service, whichever bank was executing.
- R6: A request in the same cycle as a jump, call or return does not change that transfer's target, bit 11 included. The request is vectored in the next cycle, and the address pushed is the transfer's target.
- R7: While in service, jumps and calls go to bank 0 whatever the bank flag holds, and new interrupt requests are ignored.
- R8: A return loads all 12 bits from pop_addr_i and leaves in-service unchanged. A return-from-interrupt does the same and also clears in-service.
- R9: fetch_ext_o is 1 when ext_access_i is 1. Otherwise it is 1 exactly when the program counter is at or above the internal memory size (1024 words by default).
- R10: Priority, from highest to lowest: return or return-from-interrupt, then call, then jump, then interrupt entry, then increment. With no strobe, the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Step to the next address within the bank |
| jmp_i | input | 1 | Load jump target |
| call_i | input | 1 | Load call target and push the return address |
| ret_i | input | 1 | Return: load pop_addr_i |
| reti_i | input | 1 | Return from interrupt: load pop_addr_i and leave service |
| sel_bank0_i | input | 1 | Clear the bank flag |
| sel_bank1_i | input | 1 | Set the bank flag |
| irq_ext_i | input | 1 | External interrupt request |
| irq_tmr_i | input | 1 | Timer interrupt request |
| ext_access_i | input | 1 | Force all fetches to external memory |
| operand_i | input | 11 | Jump or call target within the bank |
| pop_addr_i | input | 12 | Address popped from the return stack |
| pc_o | output | 12 | Current fetch address |
| push_en_o | output | 1 | Push strobe to the return stack |
| push_addr_o | output | 12 | Address to push |
| bank_flag_o | output | 1 | Current bank flag |
| in_service_o | output | 1 | Interrupt in service |
| fetch_ext_o | output | 1 | Current fetch goes to external memory |

## Verification
A sweep jumps to every 12-bit address with the matching bank flag, checks the load and the internal/external decision with external access both low and high, then increments. Together these show that bit 11 survives the carry out of bit 10, at both 7FFh and FFFh. Directed sequences put interrupt requests alone, in pairs, and together with jumps from bank 1, inside and outside service. This separates a vector corrupted by the executing bank, a jump target corrupted by a coincident request, a dropped pending request, and a bank switch leaking into a service routine. Plain and interrupt returns are then told apart by the in-service state they leave behind.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int ADDR_W   = 12;
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int OFF_W    = ADDR_W - 1;

    localparam logic [ADDR_W-1:0] VEC_EXT = 12'h003;
    localparam logic [ADDR_W-1:0] VEC_TMR = 12'h007;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic inc;
        logic jmp;
        logic call;
        logic ret;
        logic reti;
    } flow_t;

    function automatic addr_t step_in_bank(addr_t a);
        logic [OFF_W-1:0] off;
        off = a[OFF_W-1:0] + 1'b1;
        return {a[BANK_BIT], off};
    endfunction

    function automatic logic is_transfer(flow_t f);
        return f.jmp | f.call | f.ret | f.reti;
    endfunction
endpackage

// File: rtl/pcu_irq_ctl.sv
module pcu_irq_ctl
    import pcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel0,
    input  logic sel1,
    input  logic req_ext,
    input  logic req_tmr,
    input  logic busy,
    input  logic leave,
    output logic bank_flag,
    output logic in_service,
    output logic take,
    output logic take_ext
);
    logic pend_ext, pend_tmr;
    logic want_ext, want_tmr;

    assign want_ext = !in_service && (pend_ext || req_ext);
    assign want_tmr = !in_service && (pend_tmr || req_tmr);
    assign take     = (want_ext || want_tmr) && !busy;
    assign take_ext = want_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_flag  <= 1'b0;
            in_service <= 1'b0;
            pend_ext   <= 1'b0;
            pend_tmr   <= 1'b0;
        end else begin
            if (sel1)      bank_flag <= 1'b1;
            else if (sel0) bank_flag <= 1'b0;

            if (take) begin
                in_service <= 1'b1;
                pend_ext   <= 1'b0;
                pend_tmr   <= 1'b0;
            end else begin
                if (leave) in_service <= 1'b0;
                if (busy && !in_service) begin
                    pend_ext <= pend_ext | req_ext;
                    pend_tmr <= pend_tmr | req_tmr;
                end
            end
        end
    end
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
    import pcu_pkg::*;
(
    input  addr_t            pc,
    input  flow_t            flow,
    input  logic [OFF_W-1:0] operand,
    input  addr_t            pop_addr,
    input  logic             bank_eff,
    input  logic             take,
    input  logic             take_ext,
    output addr_t            next_pc,
    output logic             push_en,
    output addr_t            push_addr
);
    always_comb begin
        next_pc   = pc;
        push_en   = 1'b0;
        push_addr = pc;
        if (flow.ret || flow.reti) begin
            next_pc = pop_addr;
        end else if (flow.call) begin
            next_pc = {bank_eff, operand};
            push_en = 1'b1;
        end else if (flow.jmp) begin
            next_pc = {bank_eff, operand};
        end else if (take) begin
            next_pc = take_ext ? VEC_EXT : VEC_TMR;
            push_en = 1'b1;
        end else if (flow.inc) begin
            next_pc = step_in_bank(pc);
        end
    end
endmodule

// File: rtl/pc_bank_seq.sv
module pc_bank_seq
    import pcu_pkg::*;
#(
    parameter int INT_WORDS = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc_i,
    input  logic        jmp_i,
    input  logic        call_i,
    input  logic        ret_i,
    input  logic        reti_i,
    input  logic        sel_bank0_i,
    input  logic        sel_bank1_i,
    input  logic        irq_ext_i,
    input  logic        irq_tmr_i,
    input  logic        ext_access_i,
    input  logic [10:0] operand_i,
    input  logic [11:0] pop_addr_i,
    output logic [11:0] pc_o,
    output logic        push_en_o,
    output logic [11:0] push_addr_o,
    output logic        bank_flag_o,
    output logic        in_service_o,
    output logic        fetch_ext_o
);
    localparam addr_t INT_LIMIT = addr_t'(INT_WORDS);

    flow_t flow;
    addr_t pc_q, pc_d;
    logic  bank_flag, in_service, take, take_ext;

    assign flow = '{inc: inc_i, jmp: jmp_i, call: call_i, ret: ret_i, reti: reti_i};

    pcu_irq_ctl u_irq (
        .clk        (clk),
        .rst        (rst),
        .sel0       (sel_bank0_i),
        .sel1       (sel_bank1_i),
        .req_ext    (irq_ext_i),
        .req_tmr    (irq_tmr_i),
        .busy       (is_transfer(flow)),
        .leave      (reti_i),
        .bank_flag  (bank_flag),
        .in_service (in_service),
        .take       (take),
        .take_ext   (take_ext)
    );

    pcu_next_addr u_next (
        .pc        (pc_q),
        .flow      (flow),
        .operand   (operand_i),
        .pop_addr  (pop_addr_i),
        .bank_eff  (bank_flag && !in_service),
        .take      (take),
        .take_ext  (take_ext),
        .next_pc   (pc_d),
        .push_en   (push_en_o),
        .push_addr (push_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_o         = pc_q;
    assign bank_flag_o  = bank_flag;
    assign in_service_o = in_service;
    assign fetch_ext_o  = ext_access_i || (pc_q >= INT_LIMIT);
endmodule

// File: rtl/pc_bank_seq_chk.sv
module pc_bank_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        inc_i,
    input logic        jmp_i,
    input logic        call_i,
    input logic        ret_i,
    input logic        reti_i,
    input logic        ext_access_i,
    input logic [11:0] pop_addr_i,
    input logic [11:0] pc_o,
    input logic        push_en_o,
    input logic        in_service_o,
    input logic        bank_flag_o,
    input logic        fetch_ext_o
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pc_o == 12'h000) && !in_service_o && !bank_flag_o);

    p_step_keeps_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !jmp_i && !call_i && !ret_i && !reti_i && !push_en_o)
        |=> (pc_o[11] == $past(pc_o[11])) && (pc_o[10:0] == $past(pc_o[10:0]) + 11'd1));

    p_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (push_en_o && !call_i) |=> in_service_o && ((pc_o == 12'h003) || (pc_o == 12'h007)));

    p_isr_bank0_r7: assert property (@(posedge clk) disable iff (rst)
        (in_service_o && (jmp_i || call_i) && !ret_i && !reti_i) |=> !pc_o[11]);

    p_reti_r8: assert property (@(posedge clk) disable iff (rst)
        reti_i |=> !in_service_o && (pc_o == $past(pop_addr_i)));

    p_ext_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        ext_access_i |-> fetch_ext_o);
endmodule

bind pc_bank_seq pc_bank_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .inc_i        (inc_i),
    .jmp_i        (jmp_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .ext_access_i (ext_access_i),
    .pop_addr_i   (pop_addr_i),
    .pc_o         (pc_o),
    .push_en_o    (push_en_o),
    .in_service_o (in_service_o),
    .bank_flag_o  (bank_flag_o),
    .fetch_ext_o  (fetch_ext_o)
);

// File: tb/pc_bank_seq_bench.sv
module pc_bank_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inc_i = 0, jmp_i = 0, call_i = 0, ret_i = 0, reti_i = 0;
    logic sel_bank0_i = 0, sel_bank1_i = 0, irq_ext_i = 0, irq_tmr_i = 0;
    logic ext_access_i = 0;
    logic [10:0] operand_i = '0;
    logic [11:0] pop_addr_i = '0;
    logic [11:0] pc_o, push_addr_o;
    logic push_en_o, bank_flag_o, in_service_o, fetch_ext_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pc_bank_seq u_pc_bank_seq (.*);

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        {inc_i, jmp_i, call_i, ret_i, reti_i} = '0;
        {sel_bank0_i, sel_bank1_i, irq_ext_i, irq_tmr_i} = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        chk("R1 pc", pc_o, 12'h000);
        chk("R1 bank", {11'd0, bank_flag_o}, 12'h0);
        chk("R1 service", {11'd0, in_service_o}, 12'h0);
        chk("R10 hold", pc_o, 12'h000);

        // Sweep: every address via jump, then step within bank
        for (int a = 0; a < 4096; a++) begin
            logic [11:0] ad;
            ad = 12'(a);
            sel_bank1_i = ad[11]; sel_bank0_i = 1'b1;
            tick(); idle();
            jmp_i = 1; operand_i = ad[10:0];
            tick(); idle();
            chk("R3 jump target", pc_o, ad);
            ext_access_i = 0; #0.5;
            chk("R9 internal/external", {11'd0, fetch_ext_o}, {11'd0, (a >= 1024)});
            ext_access_i = 1; #0.5;
            chk("R9 forced external", {11'd0, fetch_ext_o}, 12'h1);
            ext_access_i = 0;
            inc_i = 1;
            tick(); idle();
            chk("R2 step in bank", pc_o, {ad[11], 11'(ad[10:0] + 11'd1)});
        end

        // Both selects: bank 1 wins
        sel_bank0_i = 1; sel_bank1_i = 1; tick(); idle();
        chk("R3 select priority", {11'd0, bank_flag_o}, 12'h1);

        // Call pushes current pc; call beats jump and increment
        jmp_i = 1; operand_i = 11'h234; tick(); idle();
        call_i = 1; jmp_i = 1; inc_i = 1; operand_i = 11'h055; #0.5;
        chk("R4 push strobe", {11'd0, push_en_o}, 12'h1);
        chk("R4 push addr", push_addr_o, 12'hA34);
        tick(); idle();
        chk("R10 call over jump", pc_o, 12'h855);

        // Interrupt coinciding with jump into bank 1
        jmp_i = 1; irq_ext_i = 1; operand_i = 11'h123; #0.5;
        chk("R6 no push during jump", {11'd0, push_en_o}, 12'h0);
        tick(); idle();
        chk("R6 jump target kept", pc_o, 12'h923);
        #0.5;
        chk("R6 pending push", {11'd0, push_en_o}, 12'h1);
        chk("R6 pushed target", push_addr_o, 12'h923);
        tick();
        chk("R5 external vector", pc_o, 12'h003);
        chk("R5 in service", {11'd0, in_service_o}, 12'h1);

        // In service: bank flag ignored, requests ignored
        jmp_i = 1; operand_i = 11'h456; tick(); idle();
        chk("R7 jump stays bank 0", pc_o, 12'h456);
        call_i = 1; operand_i = 11'h777; tick(); idle();
        chk("R7 call stays bank 0", pc_o, 12'h777);
        irq_tmr_i = 1; inc_i = 1; #0.5;
        chk("R7 request ignored", {11'd0, push_en_o}, 12'h0);
        tick(); idle();
        chk("R7 step not vectored", pc_o, 12'h778);

        // Plain return keeps service, interrupt return clears it
        ret_i = 1; pop_addr_i = 12'hABC; tick(); idle();
        chk("R8 return addr", pc_o, 12'hABC);
        chk("R8 return keeps service", {11'd0, in_service_o}, 12'h1);
        reti_i = 1; pop_addr_i = 12'h923; tick(); idle();
        chk("R8 reti addr", pc_o, 12'h923);
        chk("R8 reti clears service", {11'd0, in_service_o}, 12'h0);

        // Timer from bank 1, beats increment
        irq_tmr_i = 1; inc_i = 1; #0.5;
        chk("R5 timer push addr", push_addr_o, 12'h923);
        tick(); idle();
        chk("R5 timer vector", pc_o, 12'h007);
        reti_i = 1; pop_addr_i = 12'hF00; tick(); idle();

        // Both requests: external wins
        irq_ext_i = 1; irq_tmr_i = 1; tick(); idle();
        chk("R5 external priority", pc_o, 12'h003);

        rst = 1; tick(); rst = 0;
        chk("R1 reset pc", pc_o, 12'h000);
        chk("R1 reset service", {11'd0, in_service_o}, 12'h0);
        chk("R1 reset bank", {11'd0, bank_flag_o}, 12'h0);
        finish_run();
    end
endmodule